// File: doc/BRIEF.md
# Sub-word Data Memory Port

This block is a word-organised data store with a single load/store port, sized for a 32-bit in-order processor. Each entry holds one 32-bit word. The entry is chosen by the byte address with its two lowest bits dropped. Those two low bits give the lane offset inside the word.

A load reads the selected word without a clock. For byte and halfword sizes, the word is shifted right by the lane offset times eight, so the wanted data sits at bit 0. The result is then masked to its width and either zero-extended or sign-extended. A store reads the same word, places the new byte or halfword at the lane offset, and keeps every other bit. It writes the merged word back on the rising clock edge. The same shift-and-mask logic serves all access sizes. A synchronous, active-high reset clears the whole store to zero.

Top module: `subword_mem_port`

## Requirements
- R1: While reset is high and at the first clock edge after it falls, every word in the store reads as zero.
- R2: When neither the read strobe nor the write strobe is high, the read data output is zero.
- R3: A load with size code 2 returns the whole stored word unshifted. Size code 3 behaves the same as code 2.
- R4: A load with size code 0 returns the stored word shifted right by offset×8, keeping its low 8 bits.
- R5: A load with size code 1 returns the stored word shifted right by offset×8, keeping its low 16 bits. Halfword addresses are assumed to be 16-bit aligned.
- R6: When the sign flag is 1, a byte load copies bit 7 into bits 31:8, and a halfword load copies bit 15 into bits 31:16.
- R7: When the sign flag is 0, the bits above a loaded byte or halfword are zero.
- R8: A store with size code 0 replaces only bits offset×8+7 down to offset×8 with write-data bits 7:0.
- R9: A store with size code 1 replaces only bits offset×8+15 down to offset×8 with write-data bits 15:0.
- R10: A store with size code 2 replaces the whole word. The sign flag has no effect on stores.
- R11: A store takes effect at the rising clock edge. A read in the same cycle as a store returns the old contents.
- R12: A store changes no word other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the store |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data, right-aligned for sub-word sizes |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 treated as word |
| sext_i | input | 1 | 1 sign-extends sub-word loads, 0 zero-extends them |
| rdata_o | output | 32 | Load data |

## Verification
The checker tests these on every cycle:
- The output is zero whenever both strobes are low.
- The upper bits of each byte or halfword load hold the correct sign or zero fill.
- The store reads as zero right after reset.
- A word store can be read back in full on the next cycle.

Other behaviour can only be shown by the bench's sequences of accesses:
- A byte or halfword store keeps the untouched lanes of its word.
- A store leaves neighbouring words unchanged.
- Lanes are selected correctly at every offset.
- A read in the same cycle as a store returns the old word.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int OFS_W  = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Bit distance of a lane from bit 0
  function automatic logic [4:0] lane_shift(input logic [OFS_W-1:0] ofs);
    return {ofs, 3'b000};
  endfunction

  // Mask of the bits an access of the given size covers, before shifting
  function automatic logic [WORD_W-1:0] size_mask(input acc_size_e sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/smp_word_array.sv
module smp_word_array #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wword,
  output logic [WIDTH-1:0] rword
);
  logic [WIDTH-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wword;
    end
  end

  assign rword = mem_q[idx];
endmodule

// File: rtl/smp_lane_extract.sv
module smp_lane_extract
  import smp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  acc_size_e         size_i,
  input  logic              sext_i,
  output logic [WORD_W-1:0] value_o
);
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] keep;
  logic              sign_bit;

  always_comb begin
    shifted = word_i >> lane_shift(ofs_i);
    keep    = size_mask(size_i);
    case (size_i)
      SZ_BYTE: sign_bit = sext_i & shifted[LANE_W-1];
      SZ_HALF: sign_bit = sext_i & shifted[2*LANE_W-1];
      default: sign_bit = 1'b0;
    endcase
    if (size_i == SZ_WORD || size_i == SZ_RSVD)
      value_o = word_i;
    else
      value_o = (shifted & keep) | ({WORD_W{sign_bit}} & ~keep);
  end
endmodule

// File: rtl/smp_lane_merge.sv
module smp_lane_merge
  import smp_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  acc_size_e         size_i,
  output logic [WORD_W-1:0] merged_o
);
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] placed;

  always_comb begin
    lane_mask = size_mask(size_i) << lane_shift(ofs_i);
    placed    = data_i << lane_shift(ofs_i);
    merged_o  = (old_i & ~lane_mask) | (placed & lane_mask);
  end
endmodule

// File: rtl/subword_mem_port.sv
module subword_mem_port
  import smp_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - OFS_W,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  output logic [31:0]       rdata_o
);
  logic [IDX_W-1:0]  idx;
  logic [OFS_W-1:0]  ofs;
  acc_size_e         sz;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] load_val;

  assign idx = addr_i[ADDR_W-1:OFS_W];
  assign ofs = addr_i[OFS_W-1:0];
  assign sz  = acc_size_e'(size_i);

  smp_word_array #(.WORDS(WORDS), .WIDTH(WORD_W)) array_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en_i),
    .idx   (idx),
    .wword (new_word),
    .rword (cur_word)
  );

  smp_lane_merge merge_i (
    .old_i    (cur_word),
    .data_i   (wdata_i),
    .ofs_i    (ofs),
    .size_i   (sz),
    .merged_o (new_word)
  );

  smp_lane_extract extract_i (
    .word_i  (cur_word),
    .ofs_i   (ofs),
    .size_i  (sz),
    .sext_i  (sext_i),
    .value_o (load_val)
  );

  assign rdata_o = (rd_en_i || wr_en_i) ? load_val : '0;
endmodule

// File: rtl/subword_mem_port_chk.sv
module subword_mem_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [1:0]        size_i,
  input logic              sext_i,
  input logic [31:0]       rdata_o
);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_i && !wr_en_i) |-> (rdata_o == 32'h0));

  p_after_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (rd_en_i || wr_en_i)) |-> (rdata_o == 32'h0));

  p_byte_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && size_i == 2'd0 && sext_i) |-> (rdata_o[31:8] == {24{rdata_o[7]}}));

  p_byte_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && size_i == 2'd0 && !sext_i) |-> (rdata_o[31:8] == 24'h0));

  p_half_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && size_i == 2'd1 && sext_i) |-> (rdata_o[31:16] == {16{rdata_o[15]}}));

  p_half_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && size_i == 2'd1 && !sext_i) |-> (rdata_o[31:16] == 16'h0));

  p_word_store_seen_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && size_i == 2'd2) |=>
      (!(rd_en_i && size_i == 2'd2 && addr_i == $past(addr_i)) ||
       rdata_o == $past(wdata_i)));
endmodule

bind subword_mem_port subword_mem_port_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .size_i  (size_i),
  .sext_i  (sext_i),
  .rdata_o (rdata_o)
);

// File: tb/subword_mem_port_tb_top.sv
module subword_mem_port_tb_top;
  localparam int ADDR_W = 8;
  localparam time CLK_P = 8ns;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        sext;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 32'h8877_6655, 2'd2, 1'b0, 32'h0,         4'd10}, // R10 word store
    '{1'b0, 8'h10, 32'h0,         2'd2, 1'b0, 32'h8877_6655, 4'd3},  // R3
    '{1'b0, 8'h10, 32'h0,         2'd0, 1'b0, 32'h0000_0055, 4'd4},  // R4
    '{1'b0, 8'h13, 32'h0,         2'd0, 1'b1, 32'hFFFF_FF88, 4'd6},  // R6
    '{1'b0, 8'h13, 32'h0,         2'd0, 1'b0, 32'h0000_0088, 4'd7},  // R7
    '{1'b0, 8'h12, 32'h0,         2'd0, 1'b1, 32'h0000_0077, 4'd6},  // R6 positive
    '{1'b0, 8'h10, 32'h0,         2'd1, 1'b1, 32'h0000_6655, 4'd5},  // R5
    '{1'b0, 8'h12, 32'h0,         2'd1, 1'b1, 32'hFFFF_8877, 4'd6},  // R6 half
    '{1'b0, 8'h12, 32'h0,         2'd1, 1'b0, 32'h0000_8877, 4'd7},  // R7 half
    '{1'b1, 8'h11, 32'hAAAA_AAC3, 2'd0, 1'b1, 32'h0,         4'd8},  // R8 byte store
    '{1'b0, 8'h10, 32'h0,         2'd2, 1'b0, 32'h8877_C355, 4'd8},  // R8
    '{1'b1, 8'h12, 32'h1234_F00D, 2'd1, 1'b0, 32'h0,         4'd9},  // R9 half store
    '{1'b0, 8'h10, 32'h0,         2'd2, 1'b0, 32'hF00D_C355, 4'd9},  // R9
    '{1'b0, 8'h11, 32'h0,         2'd0, 1'b1, 32'hFFFF_FFC3, 4'd6},  // R6
    '{1'b0, 8'h14, 32'h0,         2'd2, 1'b0, 32'h0,         4'd12}, // R12
    '{1'b1, 8'h14, 32'hDEAD_BEEF, 2'd2, 1'b1, 32'h0,         4'd10}, // R10
    '{1'b0, 8'h10, 32'h0,         2'd2, 1'b0, 32'hF00D_C355, 4'd12}, // R12
    '{1'b0, 8'h16, 32'h0,         2'd1, 1'b1, 32'hFFFF_DEAD, 4'd5},  // R5
    '{1'b0, 8'h14, 32'h0,         2'd3, 1'b1, 32'hDEAD_BEEF, 4'd3},  // R3 code 3
    '{1'b1, 8'hFF, 32'h0000_007F, 2'd0, 1'b0, 32'h0,         4'd8},  // R8 top lane
    '{1'b0, 8'hFF, 32'h0,         2'd0, 1'b1, 32'h0000_007F, 4'd4},  // R4
    '{1'b0, 8'hFC, 32'h0,         2'd2, 1'b0, 32'h7F00_0000, 4'd8}   // R8
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              rd_en_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [1:0]        size_i = '0;
  logic              sext_i = 1'b0;
  logic [31:0]       rdata_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  subword_mem_port #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .size_i(size_i),
    .sext_i(sext_i), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let the combinational read settle
  task automatic drive(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] d, input logic [1:0] s, input logic x);
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d; size_i = s; sext_i = x;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_en_i = 1'b0; wr_en_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    drive(1'b0, 1'b1, 8'h10, 32'h0, 2'd2, 1'b0);
    check("R1", rdata_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, !VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].size, VECS[i].sext);
      if (!VECS[i].wr) check($sformatf("R%0d", VECS[i].req), rdata_o, VECS[i].exp);
    end

    // R2: idle output is zero even though addressed word is non-zero
    drive(1'b0, 1'b0, 8'h14, 32'h0, 2'd2, 1'b0);
    check("R2", rdata_o, 32'h0);

    // R11: same-cycle read sees old data, next cycle sees new
    drive(1'b1, 1'b1, 8'h20, 32'h1357_9BDF, 2'd2, 1'b0);
    check("R11", rdata_o, 32'h0);
    drive(1'b0, 1'b1, 8'h20, 32'h0, 2'd2, 1'b0);
    check("R11", rdata_o, 32'h1357_9BDF);

    // R1: a second reset clears stored words
    do_reset();
    drive(1'b0, 1'b1, 8'h10, 32'h0, 2'd2, 1'b0);
    check("R1", rdata_o, 32'h0);
    drive(1'b0, 1'b1, 8'h14, 32'h0, 2'd2, 1'b0);
    check("R1", rdata_o, 32'h0);

    drive(1'b0, 1'b0, 8'h0, 32'h0, 2'd0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule